// File: doc/BRIEF.md
# Skip-and-Halt Opcode Sequencer

This block sits on the fetch side of an 8-bit processor core and watches an instruction byte stream. It sorts each opcode byte into one of five classes: a plain no-op, a skip that swallows one operand byte, a skip that swallows two operand bytes, a halt, or anything else. It takes in the operand bytes a skip needs. It holds the instruction for its full execution time, counted in clock cycles. When it finishes an instruction it reports the class and the number of cycles that instruction took.

A two-byte skip forms an address from its two operand bytes and issues a dummy read strobe carrying that address. The data that comes back is not used. The indexed two-byte forms take one extra cycle when the core signals a page crossing on `page_cross_i`. Address arithmetic itself is not done here.

A halt opcode locks the sequencer. From then on it accepts no bytes, and only the active-low asynchronous reset brings it back.

Top module: `skip_halt_seq`

## Requirements
- R1: After reset, byte_ready_o is 1, and busy_o, halted_o, done_o and dummy_rd_o are all 0.
- R2: Any opcode whose low nibble is 0x2 and whose high nibble is 0-7, 9, B, D or F is a halt. The cycle after it is accepted, halted_o goes to 1 and byte_ready_o goes to 0. Both stay that way, and later valid bytes produce no done_o.
- R3: Asserting rst_ni low clears the halted state. After reset is released, the sequencer accepts and executes opcodes normally.
- R4: The opcodes 0x1A, 0x3A, 0x5A, 0x7A, 0xDA, 0xFA and 0xEA are no-ops (class code 1). They take no operand bytes and complete in 2 cycles.
- R5: The opcodes 0x80, 0x82, 0x89, 0xC2 and 0xE2 (2 cycles), 0x04, 0x44 and 0x64 (3 cycles), and 0x14, 0x34, 0x54, 0x74, 0xD4 and 0xF4 (4 cycles) are one-byte skips (class code 2). Each takes exactly one operand byte, and that byte is never decoded as an opcode.
- R6: The opcodes 0x0C, 0x1C, 0x3C, 0x5C, 0x7C, 0xDC and 0xFC are two-byte skips (class code 3). Each takes two operand bytes, the first being the low address byte. One cycle after the second byte is accepted, dummy_rd_o pulses for one cycle with dummy_addr_o = {second, first}. The instruction completes in 4 cycles.
- R7: page_cross_i is sampled in the cycle the second address byte is accepted. If it is 1 there, the indexed two-byte skips (all except 0x0C) take 5 cycles. It has no effect on 0x0C or on any other class.
- R8: Every other opcode is class code 0. It takes no operand bytes, gives done_o in the next cycle with a cycle count of 1, and keeps byte_ready_o at 1.
- R9: The cycle count is the number of cycles from opcode acceptance through completion. An instruction completes only after all of its operands have been accepted and its minimum time has passed. byte_ready_o is 1 only while idle or while operands are still owed.
- R10: done_o pulses for one cycle, carrying done_class_o and done_cyc_o, in the cycle after the instruction's last cycle. The next opcode can be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_i | input | 8 | Stream byte (opcode or operand) |
| page_cross_i | input | 1 | Indexed address crosses a page |
| byte_ready_o | output | 1 | Sequencer accepts a byte this cycle |
| busy_o | output | 1 | Instruction in progress |
| halted_o | output | 1 | Locked by a halt opcode |
| dummy_rd_o | output | 1 | One-cycle dummy read strobe |
| dummy_addr_o | output | 16 | Address of the dummy read |
| done_o | output | 1 | Instruction completed |
| done_class_o | output | 3 | Class code: 0 other, 1 no-op, 2 one-byte skip, 3 two-byte skip |
| done_cyc_o | output | CYC_W | Cycles the completed instruction took |

## Verification
Normally the dummy read strobe comes one cycle before completion. The two can fall in the same cycle, however, when the high address byte of a two-byte skip is held back until the minimum execution time has already run out. The bench provokes this by stalling each operand of an indexed skip with a page crossing by two cycles. It expects dummy_rd_o and done_o to be seen together, with the correct address and a cycle count of 7 instead of 5. Stalled one-byte skips are checked in the same way, against the larger of their minimum time and their operand arrival time.

// File: rtl/skh_pkg.sv
package skh_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    CLS_OTHER = 3'd0,
    CLS_NOP   = 3'd1,
    CLS_SKIP1 = 3'd2,
    CLS_SKIP2 = 3'd3,
    CLS_HALT  = 3'd4
  } cls_e;

  typedef struct packed {
    cls_e       cls;
    logic [1:0] n_opnd;
    logic [2:0] need;
    logic       idx;
  } dec_t;
endpackage

// File: rtl/skh_decode.sv
module skh_decode
  import skh_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  output dec_t              dec_o
);
  logic is_halt;

  // low nibble 2 except 82/A2/C2/E2
  assign is_halt = (op_i[3:0] == 4'h2) && (!op_i[7] || op_i[4]);

  always_comb begin
    dec_o = '{cls: CLS_OTHER, n_opnd: 2'd0, need: 3'd1, idx: 1'b0};
    if (is_halt) begin
      dec_o.cls = CLS_HALT;
    end else begin
      case (op_i)
        8'h80, 8'h82, 8'h89, 8'hC2, 8'hE2:
          dec_o = '{cls: CLS_SKIP1, n_opnd: 2'd1, need: 3'd2, idx: 1'b0};
        8'h04, 8'h44, 8'h64:
          dec_o = '{cls: CLS_SKIP1, n_opnd: 2'd1, need: 3'd3, idx: 1'b0};
        8'h14, 8'h34, 8'h54, 8'h74, 8'hD4, 8'hF4:
          dec_o = '{cls: CLS_SKIP1, n_opnd: 2'd1, need: 3'd4, idx: 1'b0};
        8'h0C:
          dec_o = '{cls: CLS_SKIP2, n_opnd: 2'd2, need: 3'd4, idx: 1'b0};
        8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'hDC, 8'hFC:
          dec_o = '{cls: CLS_SKIP2, n_opnd: 2'd2, need: 3'd4, idx: 1'b1};
        8'h1A, 8'h3A, 8'h5A, 8'h7A, 8'hDA, 8'hFA, 8'hEA:
          dec_o = '{cls: CLS_NOP, n_opnd: 2'd0, need: 3'd2, idx: 1'b0};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/skh_timer.sv
module skh_timer #(
  parameter int unsigned CYC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  output logic [CYC_W-1:0] nxt_o
);
  localparam logic [CYC_W-1:0] CNT_MAX = '1;

  logic [CYC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (start_i)                   cnt_q <= CYC_W'(1);
    else if (run_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // saturating count including the current cycle
  assign nxt_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  // R9
  run_started_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q != '0);
endmodule

// File: rtl/skh_ctrl.sv
module skh_ctrl
  import skh_pkg::*;
#(
  parameter int unsigned CYC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              page_cross_i,
  input  dec_t              dec_i,
  input  logic [CYC_W-1:0]  nxt_i,
  output logic              ready_o,
  output logic              start_o,
  output logic              run_o,
  output logic              busy_o,
  output logic              halted_o,
  output logic              dummy_rd_o,
  output logic [2*BYTE_W-1:0] dummy_addr_o,
  output logic              done_o,
  output cls_e              done_cls_o,
  output logic [CYC_W-1:0]  done_cyc_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_HALT} st_e;

  st_e               st_q;
  logic [1:0]        left_q;
  logic [2:0]        need_q;
  logic              idx_q;
  cls_e              cls_q;
  logic [BYTE_W-1:0] lo_q;

  logic       take, op_take, opd_take, last_opd, fin;
  logic [2:0] need_eff;

  assign ready_o  = (st_q == ST_IDLE) || (st_q == ST_EXEC && left_q != 2'd0);
  assign take     = valid_i && ready_o;
  assign op_take  = take && st_q == ST_IDLE;
  assign opd_take = take && st_q == ST_EXEC;
  assign last_opd = opd_take && left_q == 2'd1;
  // page crossing only counts on the final address byte of indexed forms
  assign need_eff = need_q + {2'b00, last_opd && idx_q && page_cross_i};
  assign fin      = (st_q == ST_EXEC) && (left_q == 2'd0 || last_opd)
                    && (nxt_i >= CYC_W'(need_eff));

  assign start_o  = op_take && dec_i.cls != CLS_HALT && dec_i.cls != CLS_OTHER;
  assign run_o    = st_q == ST_EXEC;
  assign busy_o   = st_q == ST_EXEC;
  assign halted_o = st_q == ST_HALT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      left_q       <= '0;
      need_q       <= '0;
      idx_q        <= 1'b0;
      cls_q        <= CLS_OTHER;
      lo_q         <= '0;
      dummy_rd_o   <= 1'b0;
      dummy_addr_o <= '0;
      done_o       <= 1'b0;
      done_cls_o   <= CLS_OTHER;
      done_cyc_o   <= '0;
    end else begin
      done_o     <= 1'b0;
      dummy_rd_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (op_take) begin
          cls_q <= dec_i.cls;
          case (dec_i.cls)
            CLS_HALT: st_q <= ST_HALT;
            CLS_OTHER: begin
              done_o     <= 1'b1;
              done_cls_o <= CLS_OTHER;
              done_cyc_o <= CYC_W'(1);
            end
            default: begin
              st_q   <= ST_EXEC;
              left_q <= dec_i.n_opnd;
              need_q <= dec_i.need;
              idx_q  <= dec_i.idx;
            end
          endcase
        end
        ST_EXEC: begin
          if (opd_take) begin
            left_q <= left_q - 2'd1;
            lo_q   <= byte_i;
          end
          if (last_opd) begin
            need_q <= need_eff;
            if (cls_q == CLS_SKIP2) begin
              dummy_rd_o   <= 1'b1;
              dummy_addr_o <= {byte_i, lo_q};
            end
          end
          if (fin) begin
            st_q       <= ST_IDLE;
            done_o     <= 1'b1;
            done_cls_o <= cls_q;
            done_cyc_o <= nxt_i;
          end
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  // R2
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  // R2
  halt_noready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !ready_o && !done_o);
  // R6
  dummy_cls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_rd_o |-> cls_q == CLS_SKIP2);
  // R6
  dummy_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_rd_o |=> !dummy_rd_o);
  // R4
  nop_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_cls_o == CLS_NOP) |-> done_cyc_o >= CYC_W'(2));
  // R7
  skip2_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_cls_o == CLS_SKIP2) |-> done_cyc_o >= CYC_W'(4));
  // R8
  other_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_take && dec_i.cls == CLS_OTHER) |=> done_o && done_cls_o == CLS_OTHER && ready_o);
endmodule

// File: rtl/skip_halt_seq.sv
module skip_halt_seq
  import skh_pkg::*;
#(
  parameter int unsigned CYC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              page_cross_i,
  output logic              byte_ready_o,
  output logic              busy_o,
  output logic              halted_o,
  output logic              dummy_rd_o,
  output logic [15:0]       dummy_addr_o,
  output logic              done_o,
  output logic [2:0]        done_class_o,
  output logic [CYC_W-1:0]  done_cyc_o
);
  dec_t             dec;
  logic             start, run;
  logic [CYC_W-1:0] nxt;
  cls_e             done_cls;

  skh_decode u_dec (
    .op_i  (byte_i),
    .dec_o (dec)
  );

  skh_timer #(.CYC_W(CYC_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (run),
    .nxt_o   (nxt)
  );

  skh_ctrl #(.CYC_W(CYC_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (byte_valid_i),
    .byte_i       (byte_i),
    .page_cross_i (page_cross_i),
    .dec_i        (dec),
    .nxt_i        (nxt),
    .ready_o      (byte_ready_o),
    .start_o      (start),
    .run_o        (run),
    .busy_o       (busy_o),
    .halted_o     (halted_o),
    .dummy_rd_o   (dummy_rd_o),
    .dummy_addr_o (dummy_addr_o),
    .done_o       (done_o),
    .done_cls_o   (done_cls),
    .done_cyc_o   (done_cyc_o)
  );

  assign done_class_o = done_cls;
endmodule

// File: tb/skip_halt_seq_tb_top.sv
module skip_halt_seq_tb_top;
  localparam int CYC_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, pc = 1'b0;
  logic [7:0] bte = 8'h00;
  logic ready, busy, halted, drd, done;
  logic [15:0] daddr;
  logic [2:0] dcls;
  logic [CYC_W-1:0] dcyc;

  int checks = 0, errors = 0;
  logic last_both;

  always #2 clk = ~clk;

  skip_halt_seq #(.CYC_W(CYC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(valid), .byte_i(bte),
    .page_cross_i(pc), .byte_ready_o(ready), .busy_o(busy), .halted_o(halted),
    .dummy_rd_o(drd), .dummy_addr_o(daddr), .done_o(done),
    .done_class_o(dcls), .done_cyc_o(dcyc)
  );

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] b1;
    logic [7:0] b2;
    logic       pc;
    logic [2:0] cls;
    logic [3:0] cyc;
    logic       dum;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{8'hEA, 8'h00, 8'h00, 1'b0, 3'd1, 4'd2, 1'b0},  // R4
    '{8'h1A, 8'h00, 8'h00, 1'b1, 3'd1, 4'd2, 1'b0},  // R4
    '{8'hFA, 8'h00, 8'h00, 1'b0, 3'd1, 4'd2, 1'b0},  // R4
    '{8'h80, 8'h02, 8'h00, 1'b0, 3'd2, 4'd2, 1'b0},  // R5 halt value as operand
    '{8'h89, 8'hFF, 8'h00, 1'b0, 3'd2, 4'd2, 1'b0},  // R5
    '{8'hE2, 8'h12, 8'h00, 1'b0, 3'd2, 4'd2, 1'b0},  // R5
    '{8'h82, 8'h00, 8'h00, 1'b0, 3'd2, 4'd2, 1'b0},  // R5 not a halt
    '{8'h44, 8'h55, 8'h00, 1'b0, 3'd2, 4'd3, 1'b0},  // R5
    '{8'h04, 8'h01, 8'h00, 1'b0, 3'd2, 4'd3, 1'b0},  // R5
    '{8'hD4, 8'h10, 8'h00, 1'b0, 3'd2, 4'd4, 1'b0},  // R5
    '{8'h14, 8'h20, 8'h00, 1'b1, 3'd2, 4'd4, 1'b0},  // R7 no effect on skip1
    '{8'h0C, 8'h34, 8'h12, 1'b0, 3'd3, 4'd4, 1'b1},  // R6
    '{8'h0C, 8'hCD, 8'hAB, 1'b1, 3'd3, 4'd4, 1'b1},  // R7 non-indexed ignores
    '{8'h1C, 8'h00, 8'h80, 1'b0, 3'd3, 4'd4, 1'b1},  // R6
    '{8'hFC, 8'hFF, 8'h7F, 1'b1, 3'd3, 4'd5, 1'b1},  // R7
    '{8'h5C, 8'h01, 8'hC0, 1'b1, 3'd3, 4'd5, 1'b1},  // R7
    '{8'hA9, 8'h00, 8'h00, 1'b0, 3'd0, 4'd1, 1'b0},  // R8
    '{8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 4'd1, 1'b0},  // R8
    '{8'h8B, 8'h00, 8'h00, 1'b1, 3'd0, 4'd1, 1'b0}   // R8
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called just after a negedge; returns just after the negedge where done is seen
  task automatic run_op(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                        input logic p, input logic [2:0] ecls, input int ecyc,
                        input logic edum, input int stall, input string tag);
    int n, k, w, nop;
    logic pend, seen_d, got;
    logic [15:0] sa;
    nop = (ecls == 3'd2) ? 1 : (ecls == 3'd3) ? 2 : 0;
    chk({tag, " R10 ready for opcode"}, int'(ready), 1);
    valid = 1'b1; bte = op; pc = p;
    @(posedge clk);
    n = 1; k = 0; w = 0; pend = 1'b0; seen_d = 1'b0; got = 1'b0; sa = '0; last_both = 1'b0;
    for (int it = 0; it < 40; it++) begin
      @(negedge clk);
      if (drd) begin seen_d = 1'b1; sa = daddr; if (done) last_both = 1'b1; end
      if (done) begin got = 1'b1; break; end
      if (k < nop) begin
        chk({tag, " R9 ready while operand owed"}, int'(ready), 1);
        if (w < stall) begin valid = 1'b0; w++; end
        else begin valid = 1'b1; bte = (k == 0) ? b1 : b2; pend = 1'b1; end
      end else begin
        valid = 1'b0;
        chk({tag, " R9 ready low while waiting"}, int'(ready), 0);
      end
      @(posedge clk);
      n++;
      if (pend) begin k++; w = 0; pend = 1'b0; end
    end
    chk({tag, " R10 done seen"}, int'(got), 1);
    chk({tag, " class"}, int'(dcls), int'(ecls));
    chk({tag, " R9 reported cycles"}, int'(dcyc), ecyc);
    chk({tag, " R9 measured cycles"}, n, ecyc);
    chk({tag, " R6 dummy read"}, int'(seen_d), int'(edum));
    if (edum) chk({tag, " R6 dummy address"}, int'(sa), int'({b2, b1}));
  endtask

  task automatic do_halt(input logic [7:0] op);
    chk("R2 ready before halt", int'(ready), 1);
    valid = 1'b1; bte = op;
    @(posedge clk); @(negedge clk);
    chk("R2 halted set", int'(halted), 1);
    chk("R2 ready low", int'(ready), 0);
    bte = 8'hEA;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2 no done while halted", int'(done), 0);
      chk("R2 halted held", int'(halted), 1);
      chk("R2 ready held low", int'(ready), 0);
    end
    valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R3 reset clears halt", int'(halted), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(8'h3A, 8'h00, 8'h00, 1'b0, 3'd1, 2, 1'b0, 0, "R3 nop after halt");
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", int'(ready), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 halted", int'(halted), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 dummy", int'(drd), 0);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i].op, VEC[i].b1, VEC[i].b2, VEC[i].pc, VEC[i].cls,
             int'(VEC[i].cyc), VEC[i].dum, 0, $sformatf("vec%0d", i));

    // R6 dummy read and completion in one cycle: stalled indexed skip, page cross
    run_op(8'h5C, 8'h10, 8'h20, 1'b1, 3'd3, 7, 1'b1, 2, "R9 stalled skip2");
    chk("R6 dummy with done same cycle", int'(last_both), 1);
    run_op(8'h64, 8'h00, 8'h00, 1'b0, 3'd2, 3, 1'b0, 1, "R9 zp stall1");
    run_op(8'h64, 8'h00, 8'h00, 1'b0, 3'd2, 5, 1'b0, 3, "R9 zp stall3");
    run_op(8'h80, 8'h00, 8'h00, 1'b0, 3'd2, 4, 1'b0, 2, "R9 imm stall2");
    run_op(8'h0C, 8'h78, 8'h56, 1'b0, 3'd3, 4, 1'b0 | 1'b1, 0, "R10 back-to-back skip2");

    do_halt(8'h12);
    do_halt(8'h92);
    do_halt(8'hF2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule